// File: doc/BRIEF.md
# Command-List Greyscale Bitmap Blitter

The blitter draws rectangular greyscale bitmaps into a 2048 x 1024 pixel frame buffer. It works from a list of commands held in memory. Software sets up two table base addresses. It loads the list start address and the command count into one of two channel register sets, and then writes that channel's trigger register. The engine then reads each 64-bit command in turn. A command selects one entry of a size table and one entry of a source table. The size entry gives the width, the height and the bit depth. The source entry, combined with an offset field of the command, gives the byte address of the packed pixel data.

Pixels are unpacked from 64-bit source words, starting at the least significant end. They are expanded to an 8-bit grey level and written one at a time, in row-major order, through a frame-buffer write port. The rectangle is clipped at the right and bottom edges of the frame buffer. All memory traffic goes through one read port that has a fixed latency of one cycle.

The control is a single state machine with these states:
- `ST_IDLE` waits for a trigger.
- `ST_CMD_RD` and `ST_CMD_LD` fetch a command.
- `ST_SIZE_RD` and `ST_SIZE_LD` fetch the size entry.
- `ST_DATA_RD` and `ST_DATA_LD` fetch the source entry and form the clipped geometry.
- `ST_WORD_RD` and `ST_WORD_LD` fetch one source word.
- `ST_PIXEL` writes one pixel per cycle.
- `ST_NEXT` steps to the following command.

The transitions are as follows:
- Idle to command fetch on an accepted trigger.
- Through the size and source lookups to word fetch, or straight to `ST_NEXT` when the clipped area is empty.
- Word fetch to pixel.
- Pixel back to word fetch at a row end or when the remaining bits cannot hold another pixel.
- Pixel to `ST_NEXT` after the last pixel.
- `ST_NEXT` to command fetch, or to idle when no commands are left.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `fb_we` and `mem_rd` are low, and no frame-buffer write or memory read occurs until a trigger is accepted.
- R2: The register addresses are as follows. Channel 0 uses 0 (list base), 1 (count) and 2 (trigger). Channel 1 uses 3, 4 and 5 in the same roles. The size table base is at 6 and the source table base at 7. A trigger write with a nonzero count raises `busy` in the next cycle. The engine then processes `count` commands, command i being the 64-bit word at base + 8*i. `busy` stays high until the last pixel is written and is low again within two cycles.
- R3: A trigger whose channel count is zero does not start the engine. A trigger written while `busy` is high is ignored and is not queued.
- R4: The command fields are: destination X in bits [10:0], destination Y in [20:11], size index in [35:30], source offset in [56:48] and source table index in [63:58].
- R5: A size entry is the 32-bit word at size_base + 4*index. Its fields are width [11:0], height [23:12] and depth code [26:24]. Bits per pixel equal depth code + 1.
- R6: A source entry is the 16-bit word at source_base + 2*index. The pixel data starts at byte address (entry << 14) | (offset << 5).
- R7: A read issued with `mem_rd` in one cycle is answered on `mem_rdata` in the next cycle. The answer is the 8-byte-aligned, little-endian 64-bit word that contains `mem_addr`, and table entries are taken from the matching bytes of that word.
- R8: Every row starts with a fresh 64-bit word, and successive words are read at increasing 8-byte steps. Pixels are taken from the least significant end. When fewer bits remain than one pixel needs, those bits are dropped and the next word is read.
- R9: A pixel value p of b bits is written as grey g = p << (8 - b). The written pixel is {8'hFF, g, g, g}.
- R10: When X + width exceeds 2048, the width becomes 2048 - X. When Y + height exceeds 1024, the height becomes 1024 - Y.
- R11: Pixels are written in row-major order: X rises within a row and rows go from top to bottom, one command after another in list order.
- R12: A command whose clipped width or height is zero writes nothing, and processing continues with the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 64 | Memory read data, one cycle after the request |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_x | output | 11 | Frame-buffer column |
| fb_y | output | 10 | Frame-buffer row |
| fb_pixel | output | 32 | Pixel as alpha, then three equal grey channels |
| busy | output | 1 | Command list in progress |

## Verification
The bench builds the block with its default parameters: two channels, 32-bit addresses and a 2048 x 1024 frame. With these values a command placed at column 2047 or row 1022 reaches both clipping edges using only a few pixels. Depths of 1, 3, 5 and 6 bits exercise word refills and the dropping of leftover bits within rows of a few dozen pixels. Odd table indices select the upper halves of the memory words.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_RD,
        ST_CMD_LD,
        ST_SIZE_RD,
        ST_SIZE_LD,
        ST_DATA_RD,
        ST_DATA_LD,
        ST_WORD_RD,
        ST_WORD_LD,
        ST_PIXEL,
        ST_NEXT
    } blit_state_e;

    // command word layout
    localparam int SIDX_LSB = 30;
    localparam int OFS_LSB  = 48;
    localparam int OFS_W    = 9;
    localparam int DIDX_LSB = 58;
    localparam int IDX_W    = 6;

    // size entry layout
    localparam int SZ_W     = 12;
    localparam int SZ_H_LSB = 12;
    localparam int BPP_LSB  = 24;
    localparam int SZE_W    = 27;

    localparam int WORD_W   = 64;
    localparam int PIX_W    = 8;

endpackage

// File: rtl/blit_regs.sv
module blit_regs #(
    parameter int NCH    = 2,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int RA_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              busy,
    output logic              start,
    output logic [ADDR_W-1:0] job_base,
    output logic [CNT_W-1:0]  job_count,
    output logic [ADDR_W-1:0] size_base,
    output logic [ADDR_W-1:0] data_base
);

    localparam int SZB_ADDR = 3 * NCH;
    localparam int DTB_ADDR = 3 * NCH + 1;

    logic [ADDR_W-1:0] base_q [NCH];
    logic [CNT_W-1:0]  cnt_q  [NCH];
    logic [ADDR_W-1:0] szb_q, dtb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                base_q[c] <= '0;
                cnt_q[c]  <= '0;
            end
            szb_q <= '0;
            dtb_q <= '0;
        end else if (reg_we) begin
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == RA_W'(3 * c))
                    base_q[c] <= reg_wdata;
                if (reg_addr == RA_W'(3 * c + 1))
                    cnt_q[c] <= reg_wdata[CNT_W-1:0];
            end
            if (reg_addr == RA_W'(SZB_ADDR))
                szb_q <= reg_wdata;
            if (reg_addr == RA_W'(DTB_ADDR))
                dtb_q <= reg_wdata;
        end
    end

    // trigger decode: data value of the trigger write is ignored
    always_comb begin
        start     = 1'b0;
        job_base  = '0;
        job_count = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_we && reg_addr == RA_W'(3 * c + 2)) begin
                job_base  = base_q[c];
                job_count = cnt_q[c];
                start     = !busy && (cnt_q[c] != '0);
            end
        end
    end

    assign size_base = szb_q;
    assign data_base = dtb_q;

endmodule

// File: rtl/blit_unpack.sv
module blit_unpack
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift,
    input  logic [3:0]        bpp,
    output logic [PIX_W-1:0]  gray,
    output logic              short_next
);

    localparam int AV_W = $clog2(WORD_W) + 1;

    logic [WORD_W-1:0] word_q;
    logic [AV_W-1:0]   avail_q;
    logic [AV_W-1:0]   bpp_ext;
    logic [AV_W-1:0]   left_after;
    logic [PIX_W:0]    mask;
    logic [PIX_W-1:0]  raw;

    assign bpp_ext = AV_W'(bpp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            avail_q <= '0;
        end else if (load) begin
            word_q  <= word_in;
            avail_q <= AV_W'(WORD_W);
        end else if (shift) begin
            word_q  <= word_q >> bpp;
            avail_q <= avail_q - bpp_ext;
        end
    end

    always_comb begin
        mask       = (PIX_W+1)'(1) << bpp;
        mask       = mask - (PIX_W+1)'(1);
        raw        = word_q[PIX_W-1:0] & mask[PIX_W-1:0];
        gray       = raw << (4'd8 - bpp);
        left_after = avail_q - bpp_ext;
        short_next = left_after < bpp_ext;
    end

    // R8: a pixel is never taken from fewer bits than its depth
    a_r8_enough_bits: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (avail_q >= bpp_ext));

endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int FB_XW  = 11,
    parameter int FB_YW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] job_base,
    input  logic [CNT_W-1:0]  job_count,
    input  logic [ADDR_W-1:0] size_base,
    input  logic [ADDR_W-1:0] data_base,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              unp_load,
    output logic              unp_shift,
    output logic [3:0]        bpp,
    input  logic              short_next,
    input  logic [PIX_W-1:0]  gray,
    output logic              busy,
    output logic              fb_we,
    output logic [FB_XW-1:0]  fb_x,
    output logic [FB_YW-1:0]  fb_y,
    output logic [31:0]       fb_pixel
);

    localparam int SUM_W = SZ_W + 2;
    localparam int FB_W  = 1 << FB_XW;
    localparam int FB_H  = 1 << FB_YW;

    blit_state_e state_q, state_d;

    logic [ADDR_W-1:0] ptr_q, src_q;
    logic [CNT_W-1:0]  left_q;
    logic [FB_XW-1:0]  x_q;
    logic [FB_YW-1:0]  y_q;
    logic [IDX_W-1:0]  sidx_q, didx_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [SZ_W-1:0]   sw_q, sh_q, w_q, h_q, col_q, row_q;
    logic [2:0]        bppm1_q;

    logic [ADDR_W-1:0] size_addr, data_addr, src_addr;
    logic [SZE_W-1:0]  size_word;
    logic [15:0]       data_ent;
    logic [SUM_W-1:0]  x_ext, y_ext, sum_x, sum_y;
    logic [SZ_W-1:0]   w_clip, h_clip;
    logic              last_col, last_row;

    // table addressing and field extraction
    always_comb begin
        size_addr = size_base + ADDR_W'({sidx_q, 2'b00});
        data_addr = data_base + ADDR_W'({didx_q, 1'b0});
        size_word = SZE_W'(size_addr[2] ? mem_rdata[63:32] : mem_rdata[31:0]);
        data_ent  = mem_rdata[{data_addr[2:1], 4'b0000} +: 16];
        src_addr  = ADDR_W'({data_ent, 14'b0}) | ADDR_W'({ofs_q, 5'b0});
    end

    // edge clipping
    always_comb begin
        x_ext  = SUM_W'(x_q);
        y_ext  = SUM_W'(y_q);
        sum_x  = x_ext + SUM_W'(sw_q);
        sum_y  = y_ext + SUM_W'(sh_q);
        w_clip = (sum_x > SUM_W'(FB_W)) ? SZ_W'(SUM_W'(FB_W) - x_ext) : sw_q;
        h_clip = (sum_y > SUM_W'(FB_H)) ? SZ_W'(SUM_W'(FB_H) - y_ext) : sh_q;
    end

    assign last_col = (col_q == w_q - SZ_W'(1));
    assign last_row = (row_q == h_q - SZ_W'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CMD_RD;
            ST_CMD_RD:  state_d = ST_CMD_LD;
            ST_CMD_LD:  state_d = ST_SIZE_RD;
            ST_SIZE_RD: state_d = ST_SIZE_LD;
            ST_SIZE_LD: state_d = ST_DATA_RD;
            ST_DATA_RD: state_d = ST_DATA_LD;
            ST_DATA_LD: state_d = (w_clip == '0 || h_clip == '0) ? ST_NEXT : ST_WORD_RD;
            ST_WORD_RD: state_d = ST_WORD_LD;
            ST_WORD_LD: state_d = ST_PIXEL;
            ST_PIXEL: begin
                if (last_col)
                    state_d = last_row ? ST_NEXT : ST_WORD_RD;
                else if (short_next)
                    state_d = ST_WORD_RD;
            end
            ST_NEXT:    state_d = (left_q == CNT_W'(1)) ? ST_IDLE : ST_CMD_RD;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            src_q   <= '0;
            left_q  <= '0;
            x_q     <= '0;
            y_q     <= '0;
            sidx_q  <= '0;
            didx_q  <= '0;
            ofs_q   <= '0;
            sw_q    <= '0;
            sh_q    <= '0;
            w_q     <= '0;
            h_q     <= '0;
            col_q   <= '0;
            row_q   <= '0;
            bppm1_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ptr_q  <= job_base;
                    left_q <= job_count;
                end
                ST_CMD_LD: begin
                    x_q    <= mem_rdata[FB_XW-1:0];
                    y_q    <= mem_rdata[FB_XW+FB_YW-1:FB_XW];
                    sidx_q <= mem_rdata[SIDX_LSB +: IDX_W];
                    ofs_q  <= mem_rdata[OFS_LSB +: OFS_W];
                    didx_q <= mem_rdata[DIDX_LSB +: IDX_W];
                end
                ST_SIZE_LD: begin
                    sw_q    <= size_word[SZ_W-1:0];
                    sh_q    <= size_word[SZ_H_LSB +: SZ_W];
                    bppm1_q <= size_word[BPP_LSB +: 3];
                end
                ST_DATA_LD: begin
                    src_q <= src_addr;
                    w_q   <= w_clip;
                    h_q   <= h_clip;
                    col_q <= '0;
                    row_q <= '0;
                end
                ST_WORD_RD: src_q <= src_q + ADDR_W'(8);
                ST_PIXEL: begin
                    if (last_col) begin
                        col_q <= '0;
                        row_q <= row_q + SZ_W'(1);
                    end else begin
                        col_q <= col_q + SZ_W'(1);
                    end
                end
                ST_NEXT: begin
                    ptr_q  <= ptr_q + ADDR_W'(8);
                    left_q <= left_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = (state_q == ST_CMD_RD) || (state_q == ST_SIZE_RD) ||
                    (state_q == ST_DATA_RD) || (state_q == ST_WORD_RD);
        unique case (state_q)
            ST_CMD_RD:  mem_addr = ptr_q;
            ST_SIZE_RD: mem_addr = size_addr;
            ST_DATA_RD: mem_addr = data_addr;
            default:    mem_addr = src_q;
        endcase
        unp_load  = (state_q == ST_WORD_LD);
        unp_shift = (state_q == ST_PIXEL);
        fb_we     = (state_q == ST_PIXEL);
        busy      = (state_q != ST_IDLE);
        bpp       = {1'b0, bppm1_q} + 4'd1;
        fb_x      = x_q + FB_XW'(col_q);
        fb_y      = y_q + FB_YW'(row_q);
        fb_pixel  = {8'hFF, gray, gray, gray};
    end

    // R2: an accepted trigger makes the engine busy in the next cycle
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7: every read is followed by a cycle in which its answer is consumed
    a_r7_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R10: clipping keeps writes from wrapping past the frame edge
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (fb_x >= x_q) && (fb_y >= y_q));

    // R11: back-to-back writes advance one column within the same row
    a_r11_row_major: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> (fb_x == FB_XW'($past(fb_x) + 1'b1)) && (fb_y == $past(fb_y)));

endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter  int NCH    = 2,
    parameter  int ADDR_W = 32,
    parameter  int CNT_W  = 16,
    parameter  int FB_XW  = 11,
    parameter  int FB_YW  = 10,
    localparam int RA_W   = $clog2(3 * NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [63:0]       mem_rdata,
    output logic              fb_we,
    output logic [FB_XW-1:0]  fb_x,
    output logic [FB_YW-1:0]  fb_y,
    output logic [31:0]       fb_pixel,
    output logic              busy
);

    logic              start;
    logic [ADDR_W-1:0] job_base, size_base, data_base;
    logic [CNT_W-1:0]  job_count;
    logic              unp_load, unp_shift, short_next;
    logic [3:0]        bpp;
    logic [PIX_W-1:0]  gray;

    blit_regs #(
        .NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RA_W(RA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .start     (start),
        .job_base  (job_base),
        .job_count (job_count),
        .size_base (size_base),
        .data_base (data_base)
    );

    blit_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FB_XW(FB_XW), .FB_YW(FB_YW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .job_base   (job_base),
        .job_count  (job_count),
        .size_base  (size_base),
        .data_base  (data_base),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .unp_load   (unp_load),
        .unp_shift  (unp_shift),
        .bpp        (bpp),
        .short_next (short_next),
        .gray       (gray),
        .busy       (busy),
        .fb_we      (fb_we),
        .fb_x       (fb_x),
        .fb_y       (fb_y),
        .fb_pixel   (fb_pixel)
    );

    blit_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (unp_load),
        .word_in    (mem_rdata),
        .shift      (unp_shift),
        .bpp        (bpp),
        .gray       (gray),
        .short_next (short_next)
    );

endmodule

// File: tb/tb_blit_engine.sv
module tb_blit_engine;

    localparam int CLK_PERIOD = 10;
    localparam int SB = 32'h2000;
    localparam int DB = 32'h2400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        fb_we;
    logic [10:0] fb_x;
    logic [9:0]  fb_y;
    logic [31:0] fb_pixel;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] mem [int];
    logic [52:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    blit_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .fb_we(fb_we), .fb_x(fb_x), .fb_y(fb_y),
        .fb_pixel(fb_pixel), .busy(busy)
    );

    function automatic logic [63:0] rd64(input int unsigned a);
        int unsigned idx;
        logic [63:0] w;
        idx = a >> 3;
        if (mem.exists(int'(idx))) return mem[int'(idx)];
        w[31:0]  = (idx * 32'h9E3779B1) ^ 32'h5A5A1234;
        w[63:32] = (idx * 32'h85EBCA77) + 32'd7;
        return w;
    endfunction

    // R7: one-cycle read latency, aligned little-endian word
    always @(posedge clk) if (mem_rd) mem_rdata <= rd64(mem_addr);

    task automatic poke64(input int unsigned a, input logic [63:0] v);
        mem[int'(a >> 3)] = v;
    endtask

    task automatic poke32(input int unsigned a, input logic [31:0] v);
        logic [63:0] w;
        w = rd64(a);
        w[a[2]*32 +: 32] = v;
        mem[int'(a >> 3)] = w;
    endtask

    task automatic poke16(input int unsigned a, input logic [15:0] v);
        logic [63:0] w;
        w = rd64(a);
        w[a[2:1]*16 +: 16] = v;
        mem[int'(a >> 3)] = w;
    endtask

    function automatic logic [63:0] mk_cmd(input int x, input int y, input int si,
                                           input int ofs, input int di);
        logic [63:0] c;
        c = '0;
        c[10:0]  = 11'(x);
        c[20:11] = 10'(y);
        c[35:30] = 6'(si);
        c[56:48] = 9'(ofs);
        c[63:58] = 6'(di);
        return c;
    endfunction

    function automatic logic [31:0] mk_size(input int w, input int h, input int dm1);
        return {5'd0, 3'(dm1), 12'(h), 12'(w)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: queue the writes a list should produce
    task automatic model(input int unsigned base, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            logic [63:0] c, v;
            logic [31:0] se;
            logic [15:0] de;
            int unsigned sa, da, src;
            int x, y, w, h, b, avail;
            logic [7:0] g;
            c  = rd64(base + 8 * i);
            x  = int'(c[10:0]);
            y  = int'(c[20:11]);
            sa = SB + 4 * int'(c[35:30]);
            da = DB + 2 * int'(c[63:58]);
            v  = rd64(sa);
            se = sa[2] ? v[63:32] : v[31:0];
            v  = rd64(da);
            de = v[da[2:1]*16 +: 16];
            w  = int'(se[11:0]);
            h  = int'(se[23:12]);
            b  = 1 + int'(se[26:24]);
            if (x + w > 2048) w = 2048 - x;
            if (y + h > 1024) h = 1024 - y;
            src = (int'(de) << 14) | (int'(c[56:48]) << 5);
            for (int yy = 0; yy < h; yy++) begin
                v = rd64(src);
                src += 8;
                avail = 64;
                for (int xx = 0; xx < w; xx++) begin
                    if (avail < b) begin
                        v = rd64(src);
                        src += 8;
                        avail = 64;
                    end
                    g = 8'((v & ((64'd1 << b) - 1)) << (8 - b));
                    exp_q.push_back({11'(x + xx), 10'(y + yy), 8'hFF, g, g, g});
                    v = v >> b;
                    avail -= b;
                end
            end
        end
    endtask

    // per-clock comparison against the reference queue (R4 R5 R6 R8 R9 R10 R11)
    always @(negedge clk) begin
        if (rst_n && fb_we === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected write actual=%0h expected=none",
                         {fb_x, fb_y, fb_pixel});
            end else begin
                chk("R4/R5/R6/R8/R9/R10/R11 pixel", {11'd0, fb_x, fb_y, fb_pixel},
                    {11'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic wr(input int a, input int unsigned d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while (busy === 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog actual=busy expected=idle", req);
        end
        chk({req, " R2 busy low"}, 64'(busy), 64'd0);
        chk({req, " R2 writes drained"}, 64'(exp_q.size()), 64'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input int ch, input int unsigned base, input int cnt, input string req);
        model(base, cnt);
        wr(3 * ch, base);
        wr(3 * ch + 1, cnt);
        wr(3 * ch + 2, 0);
        chk({req, " R2 busy after trigger"}, 64'(busy), 64'd1);
        wait_idle(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // tables
        poke32(SB + 4 * 0, mk_size(4, 2, 7));
        poke32(SB + 4 * 1, mk_size(70, 2, 0));
        poke32(SB + 4 * 2, mk_size(25, 2, 2));
        poke32(SB + 4 * 3, mk_size(9, 3, 4));
        poke32(SB + 4 * 4, mk_size(0, 3, 3));
        poke32(SB + 4 * 5, mk_size(6, 4, 1));
        poke32(SB + 4 * 6, mk_size(5, 0, 1));
        poke32(SB + 4 * 9, mk_size(13, 1, 5));
        poke16(DB + 2 * 0, 16'd1);
        poke16(DB + 2 * 1, 16'd2);
        poke16(DB + 2 * 5, 16'd3);
        poke16(DB + 2 * 6, 16'd5);
        poke16(DB + 2 * 7, 16'd4);
        // lists
        poke64(32'h1000, mk_cmd(5, 7, 0, 3, 0));
        poke64(32'h1100, mk_cmd(100, 200, 1, 0, 1));
        poke64(32'h1200, mk_cmd(0, 0, 2, 17, 5));
        poke64(32'h1208, mk_cmd(30, 40, 3, 511, 6));
        poke64(32'h1300, mk_cmd(10, 10, 4, 8, 1));
        poke64(32'h1308, mk_cmd(50, 60, 9, 2, 7));
        poke64(32'h1310, mk_cmd(1, 1, 6, 9, 0));
        poke64(32'h1318, mk_cmd(20, 21, 0, 1, 1));
        poke64(32'h1400, mk_cmd(2045, 1022, 5, 4, 1));
        poke64(32'h1408, mk_cmd(2047, 0, 0, 0, 0));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy at reset", 64'(busy), 64'd0);
        chk("R1 fb_we at reset", 64'(fb_we), 64'd0);
        chk("R1 mem_rd at reset", 64'(mem_rd), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", 64'({busy, fb_we, mem_rd}), 64'd0);

        wr(6, SB);
        wr(7, DB);

        run(0, 32'h1000, 1, "R5 depth8");            // R4 R5 R6 R9
        run(0, 32'h1100, 1, "R8 depth1 refill");     // R8
        run(1, 32'h1200, 2, "R7 depth3 and depth5"); // R7 R8
        run(1, 32'h1300, 4, "R12 empty commands");   // R12
        run(0, 32'h1400, 2, "R10 clipping");         // R10

        // R3: zero count does not start
        wr(4, 0);
        wr(5, 0);
        chk("R3 zero count stays idle", 64'(busy), 64'd0);
        repeat (5) @(negedge clk);
        chk("R3 zero count no activity", 64'({busy, fb_we}), 64'd0);

        // R3: trigger while busy is ignored
        wr(3, 32'h1200);
        wr(4, 2);
        model(32'h1100, 1);
        wr(0, 32'h1100);
        wr(1, 1);
        wr(2, 0);
        chk("R3 busy for first job", 64'(busy), 64'd1);
        repeat (3) @(negedge clk);
        wr(5, 0);
        wait_idle("R3 trigger while busy");

        // R2: channel 1 registers still intact and usable afterwards
        model(32'h1200, 2);
        wr(5, 0);
        chk("R2 channel 1 restart", 64'(busy), 64'd1);
        wait_idle("R2 channel 1 job");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule